// File: doc/BRIEF.md
# Serial Transmit Engine with Sticky Parity

This block is the transmit half of an asynchronous serial port. Characters written into a small holding FIFO are sent one at a time on a single output line. Each frame has a low start bit, the data bits with the least significant bit first, an optional extra slot bit, and one or two high stop bits. The line rests high between frames. Every bit lasts 16 pulses of an externally supplied baud tick. The block does not generate that tick itself.

Line-control inputs choose the word length (5 to 8 bits) and the stop-bit count. They also choose what goes into the slot bit: nothing, odd parity, even parity, a constant 1, a constant 0, or, in 9-bit mode, the ninth data bit. A break input pulls the line low for as long as software holds it asserted. Two flags report progress. One says the holding FIFO has no entries. The other says the whole transmitter has gone quiet.

The character format is captured when a character is taken from the FIFO. A change to the line-control inputs therefore takes effect from the next frame.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame or break is in progress, `txd` is 1.
- R2: A frame begins with one low start bit. The data bits follow, least significant bit first. `wlen` selects the data-bit count: 00 means 5 bits, 01 means 6, 10 means 7 and 11 means 8. Every bit lasts exactly 16 `baud_tick` pulses, and a bit does not end while no ticks arrive.
- R3: When `nine_bit` is 0, `par_sel` chooses the slot bit that follows the data. If `par_sel[0]` is 0, no slot bit is sent. 001 sends odd parity over the data bits, 011 sends even parity, 101 sends a constant 1 and 111 sends a constant 0.
- R4: When `nine_bit` is 1, the frame carries 8 data bits from `wr_data[7:0]`. The slot bit is `wr_data[8]`, and `par_sel` and `wlen` have no effect.
- R5: The frame ends with one high stop bit when `two_stop` is 0, and with two high stop bits when `two_stop` is 1.
- R6: While `brk` is 1, `txd` is 0 from the next cycle on, whatever the frame state. Break imposes no minimum length.
- R7: `hold_empty` is 1 exactly when the holding FIFO has no entries.
- R8: `tx_idle` is 1 only when the FIFO is empty and the last stop bit has completed. It is 0 while any bit of a frame is still being sent.
- R9: If the FIFO holds a character when the last stop bit ends, its start bit follows that stop bit directly, with no idle bit time in between.
- R10: A write while the FIFO holds `DEPTH` entries is discarded. `ovf` is then 1 for one cycle, in the cycle after the write. Every character that was accepted is still sent, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick; 16 ticks make one bit |
| wr_en | input | 1 | Write strobe for the holding FIFO |
| wr_data | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| par_sel | input | 3 | Slot-bit selector (see R3) |
| nine_bit | input | 1 | 9-bit data mode |
| wlen | input | 2 | Data-bit count selector (see R2) |
| two_stop | input | 1 | Two stop bits when 1 |
| brk | input | 1 | Break: hold the line low |
| txd | output | 1 | Serial output, registered |
| hold_empty | output | 1 | Holding FIFO empty |
| tx_idle | output | 1 | FIFO empty and shifter finished |
| ovf | output | 1 | One-cycle pulse for a dropped write |

## Verification
A write is stored at the clock edge that captures it, so `hold_empty` falls in the following sample. The idle shifter pops the character one edge later, which brings `hold_empty` back to 1. The start bit appears on `txd` one edge after that, because the line passes through an output register. The bench therefore checks these three points at three consecutive falling edges after the write. From the first low sample of the start bit, it counts 7 clocks to reach the middle of that bit, then 16 clocks to the middle of each later bit. The ticks run on every cycle, so each bit is exactly 16 clocks long. `ovf` is checked in the sample after the dropped write and again one sample later. `tx_idle` is checked at the middle of the last stop bit and again 9 samples later, which is one sample after the last stop cycle. A break must show on `txd` from the first sample after `brk` rises.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CHAR_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_SLOT,
    ST_STOP
  } tx_state_t;

  // Character format captured at load time
  typedef struct packed {
    logic [7:0] bits;
    logic [3:0] nbits;
    logic       has_slot;
    logic       slot;
    logic       two_stop;
  } frame_t;

  function automatic frame_t build_frame(input logic [CHAR_W-1:0] d,
                                         input logic [2:0] psel,
                                         input logic nine,
                                         input logic [1:0] wlen,
                                         input logic two);
    frame_t     f;
    logic [3:0] n;
    n = nine ? 4'd8 : (4'd5 + {2'b00, wlen});
    for (int i = 0; i < 8; i++) begin
      f.bits[i] = d[i] & (4'(i) < n);
    end
    f.nbits    = n;
    f.two_stop = two;
    if (nine) begin
      f.has_slot = 1'b1;
      f.slot     = d[8];
    end else begin
      f.has_slot = psel[0];
      case (psel[2:1])
        2'b00:   f.slot = ~^f.bits;
        2'b01:   f.slot = ^f.bits;
        2'b10:   f.slot = 1'b1;
        default: f.slot = 1'b0;
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push    = wr_en && !full;
  assign do_pop  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      ovf <= wr_en && full;
      if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int OVERS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic [2:0]        par_sel,
  input  logic              nine_bit,
  input  logic [1:0]        wlen,
  input  logic              two_stop,
  input  logic              brk,
  output logic              pop,
  output logic              busy,
  output logic              txd
);
  localparam int TW = (OVERS > 1) ? $clog2(OVERS) : 1;

  tx_state_t     state;
  frame_t        fr;
  logic [TW-1:0] cnt;
  logic [3:0]    idx;
  logic          second;
  logic          bit_done, last_stop, line;

  assign bit_done  = tick && (cnt == TW'(OVERS - 1));
  assign last_stop = (state == ST_STOP) && (!fr.two_stop || second);
  assign pop       = !fifo_empty && ((state == ST_IDLE) || (last_stop && bit_done));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = fr.bits[0];
      ST_SLOT:  line = fr.slot;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      fr     <= '0;
      cnt    <= '0;
      idx    <= '0;
      second <= 1'b0;
      txd    <= 1'b1;
    end else begin
      txd <= brk ? 1'b0 : line;
      if (pop) begin
        fr     <= build_frame(fifo_data, par_sel, nine_bit, wlen, two_stop);
        state  <= ST_START;
        cnt    <= '0;
        idx    <= '0;
        second <= 1'b0;
      end else if (busy && tick) begin
        if (bit_done) begin
          cnt <= '0;
          case (state)
            ST_START: state <= ST_DATA;
            ST_DATA: begin
              fr.bits <= {1'b0, fr.bits[7:1]};
              idx     <= idx + 1'b1;
              if (idx == fr.nbits - 4'd1) state <= fr.has_slot ? ST_SLOT : ST_STOP;
            end
            ST_SLOT: state <= ST_STOP;
            default: begin
              if (last_stop) state <= ST_IDLE;
              else second <= 1'b1;
            end
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OVERS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic [2:0]        par_sel,
  input  logic              nine_bit,
  input  logic [1:0]        wlen,
  input  logic              two_stop,
  input  logic              brk,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_idle,
  output logic              ovf
);
  logic              pop, busy;
  logic [CHAR_W-1:0] fifo_data;

  sertx_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .rd_data(fifo_data), .empty(hold_empty), .ovf(ovf)
  );

  sertx_shifter #(.OVERS(OVERS)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .fifo_empty(hold_empty),
    .fifo_data(fifo_data), .par_sel(par_sel), .nine_bit(nine_bit),
    .wlen(wlen), .two_stop(two_stop), .brk(brk), .pop(pop), .busy(busy),
    .txd(txd)
  );

  assign tx_idle = hold_empty && !busy;
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic brk,
  input logic txd,
  input logic hold_empty,
  input logic tx_idle,
  input logic ovf
);
  // R6: break reaches the line one edge later
  p_break_low_r6: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);

  // R1: quiet line is high when no break was requested
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && !$past(brk)) |-> txd);

  // R8: idle implies nothing queued
  p_idle_empty_r8: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> hold_empty);

  // R7: without a write the FIFO stays empty
  p_empty_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (hold_empty && !wr_en) |=> hold_empty);

  // R10: overflow only follows a write into a non-empty FIFO
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($past(wr_en) && !hold_empty));
endmodule

bind sertx_top sertx_checks u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .brk(brk), .txd(txd),
  .hold_empty(hold_empty), .tx_idle(tx_idle), .ovf(ovf)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
  localparam int DEPTH = 8;

  logic       clk = 0, rst = 1, tick_en = 1;
  logic       wr_en = 0, nine_bit = 0, two_stop = 0, brk = 0;
  logic [8:0] wr_data = '0;
  logic [2:0] par_sel = 3'b000;
  logic [1:0] wlen = 2'b11;
  logic       txd, hold_empty, tx_idle, ovf;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  sertx_top #(.DEPTH(DEPTH), .OVERS(16)) u0 (
    .clk(clk), .rst(rst), .baud_tick(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .par_sel(par_sel), .nine_bit(nine_bit), .wlen(wlen), .two_stop(two_stop),
    .brk(brk), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic put(input logic [8:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_fall();
    int n = 0;
    @(negedge clk);
    while (txd !== 1'b0 && n < 3000) begin n++; @(negedge clk); end
    if (txd !== 1'b0) chk(0, "R2 no start bit seen", txd, 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (tx_idle !== 1'b1 && n < 3000) begin n++; @(negedge clk); end
    chk(tx_idle === 1'b1, "R8 transmitter never went idle", tx_idle, 1);
  endtask

  // Called at the first start-bit sample when aligned=1; ends at the middle of the last stop bit
  task automatic expect_frame(input string tag, input int nb, input logic [7:0] d,
                              input bit slot_on, input bit slot_v, input int nstop,
                              input bit aligned);
    if (!aligned) wait_fall();
    repeat (7) @(negedge clk);
    chk(txd === 1'b0, {tag, " R2 start bit"}, txd, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      chk(txd === d[i], $sformatf("%s R2 data bit %0d", tag, i), txd, d[i]);
    end
    if (slot_on) begin
      repeat (16) @(negedge clk);
      chk(txd === slot_v, {tag, " R3/R4 slot bit"}, txd, slot_v);
    end
    for (int s = 0; s < nstop; s++) begin
      repeat (16) @(negedge clk);
      chk(txd === 1'b1, $sformatf("%s R5 stop bit %0d", tag, s), txd, 1);
    end
  endtask

  task automatic test_reset();
    chk(txd === 1'b1, "R1 reset line level", txd, 1);
    chk(hold_empty === 1'b1, "R7 reset empty flag", hold_empty, 1);
    chk(tx_idle === 1'b1, "R8 reset idle flag", tx_idle, 1);
    chk(ovf === 1'b0, "R10 reset overflow", ovf, 0);
  endtask

  task automatic test_basic();
    wlen = 2'b11; par_sel = 3'b000; two_stop = 0; nine_bit = 0;
    put(9'h0A5);
    chk(hold_empty === 1'b0, "R7 empty flag after write", hold_empty, 0);
    chk(tx_idle === 1'b0, "R8 idle after write", tx_idle, 0);
    chk(txd === 1'b1, "R1 line before load", txd, 1);
    @(negedge clk);
    chk(hold_empty === 1'b1, "R7 empty once loaded", hold_empty, 1);
    chk(tx_idle === 1'b0, "R8 busy while FIFO empty", tx_idle, 0);
    @(negedge clk);
    chk(txd === 1'b0, "R2 start two edges after write", txd, 0);
    expect_frame("8N1", 8, 8'hA5, 0, 0, 1, 1);
    chk(tx_idle === 1'b0, "R8 not idle in stop bit", tx_idle, 0);
    repeat (9) @(negedge clk);
    chk(tx_idle === 1'b1, "R8 idle after stop", tx_idle, 1);
    chk(txd === 1'b1, "R1 line high when idle", txd, 1);
  endtask

  task automatic test_lengths();
    wlen = 2'b00; put(9'h03B);
    expect_frame("5bit", 5, 8'h1B, 0, 0, 1, 0); wait_idle();
    wlen = 2'b10; put(9'h0C6);
    expect_frame("7bit", 7, 8'h46, 0, 0, 1, 0); wait_idle();
    wlen = 2'b11;
  endtask

  task automatic test_parity();
    // 7-bit data 0x13 has three ones
    wlen = 2'b10;
    par_sel = 3'b001; put(9'h013); expect_frame("R3 odd",   7, 8'h13, 1, 0, 1, 0); wait_idle();
    par_sel = 3'b011; put(9'h013); expect_frame("R3 even",  7, 8'h13, 1, 1, 1, 0); wait_idle();
    par_sel = 3'b101; put(9'h013); expect_frame("R3 one",   7, 8'h13, 1, 1, 1, 0); wait_idle();
    par_sel = 3'b111; put(9'h013); expect_frame("R3 zero",  7, 8'h13, 1, 0, 1, 0); wait_idle();
    // No slot: the bit after the data must be the stop bit
    par_sel = 3'b110; put(9'h013); expect_frame("R3 none",  7, 8'h13, 0, 0, 1, 0); wait_idle();
    par_sel = 3'b000; wlen = 2'b11;
  endtask

  task automatic test_nine();
    nine_bit = 1; wlen = 2'b00;
    par_sel = 3'b011; put(9'h1C3); expect_frame("R4 nine hi", 8, 8'hC3, 1, 1, 1, 0); wait_idle();
    par_sel = 3'b101; put(9'h0FF); expect_frame("R4 nine lo", 8, 8'hFF, 1, 0, 1, 0); wait_idle();
    nine_bit = 0; par_sel = 3'b000; wlen = 2'b11;
  endtask

  task automatic test_two_stop();
    two_stop = 1; put(9'h081);
    expect_frame("R5 two stop", 8, 8'h81, 0, 0, 2, 0);
    chk(tx_idle === 1'b0, "R8 busy in second stop", tx_idle, 0);
    repeat (9) @(negedge clk);
    chk(tx_idle === 1'b1, "R8 idle after second stop", tx_idle, 1);
    two_stop = 0;
  endtask

  task automatic test_b2b();
    put(9'h03C); put(9'h0E1);
    expect_frame("R9 first", 8, 8'h3C, 0, 0, 1, 0);
    chk(tx_idle === 1'b0, "R8 busy with queued char", tx_idle, 0);
    repeat (8) @(negedge clk);
    chk(txd === 1'b1, "R9 stop bit full length", txd, 1);
    @(negedge clk);
    chk(txd === 1'b0, "R9 next start directly after stop", txd, 0);
    expect_frame("R9 second", 8, 8'hE1, 0, 0, 1, 1);
    wait_idle();
  endtask

  task automatic test_break();
    int highs = 0;
    put(9'h0FF);
    wait_fall();
    repeat (40) @(negedge clk);
    brk = 1;
    @(negedge clk);
    chk(txd === 1'b0, "R6 break next cycle", txd, 0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (txd !== 1'b0) highs++;
    end
    chk(highs == 0, "R6 line held low during break", highs, 0);
    brk = 0;
    @(negedge clk);
    wait_idle();
    chk(txd === 1'b1, "R1 line high after break", txd, 1);
  endtask

  task automatic test_overflow();
    int lows = 0;
    tick_en = 0;
    wr_en = 1;
    for (int k = 1; k <= DEPTH + 1; k++) begin
      wr_data = 9'(k);
      @(negedge clk);
    end
    wr_en = 0;
    repeat (3) @(negedge clk);
    chk(hold_empty === 1'b0, "R7 empty flag with full FIFO", hold_empty, 0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
    chk(lows == 50, "R2 bit does not end without ticks", lows, 50);
    chk(ovf === 1'b0, "R10 no pulse before overflow", ovf, 0);
    put(9'h0EE);
    chk(ovf === 1'b1, "R10 overflow pulse", ovf, 1);
    @(negedge clk);
    chk(ovf === 1'b0, "R10 overflow pulse one cycle", ovf, 0);
    tick_en = 1;
    @(negedge clk);
    expect_frame("R10 drain 1", 8, 8'h01, 0, 0, 1, 1);
    for (int k = 2; k <= DEPTH + 1; k++)
      expect_frame($sformatf("R10 drain %0d", k), 8, 8'(k), 0, 0, 1, 0);
    wait_idle();
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, "R10 dropped char never sent", lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_lengths();
    test_parity();
    test_nine();
    test_two_stop();
    test_b2b();
    test_break();
    test_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule